// File: doc/BRIEF.md
# Extended State Restore Checker

This block performs the checking and committing half of an instruction that reloads a 512-byte image of floating-point and SIMD state. It receives a restore request with its decode attributes:

- a lock prefix flag
- the operand size
- the alignment-check enable
- the current privilege level
- the operating-system enable for SIMD state
- the low four bits of the image address

It then either faults at once or takes the image as 32 beats of 128 bits through a valid/ready handshake.

The block writes the following architectural registers:

- the legacy floating-point opcode
- the instruction pointer and the data pointer
- eight 128-bit SIMD registers
- the 32-bit SIMD control/status word

Every update is staged and is only committed after the last beat has been accepted. A restore that faults therefore leaves all state as it was.

The block also drives the SIMD numeric error line. The error line follows new exception occurrences reported by the execution side. It never follows flags that are loaded from an image.

Top module: `xsr_restore`

## Requirements
- R1: A restore whose lock-prefix flag is set raises only `flt_ud_o`, accepts no beat and changes no register. The lock check takes precedence over the alignment checks.
- R2: When the image offset is not a multiple of 16 and the alignment-check exception is not selected (see R3), `flt_gp_o` is raised and nothing is loaded.
- R3: When alignment checking is enabled and the privilege level is 3, an offset with low two bits `2'b10` raises `flt_ac_o`. Under the same conditions, every other non-zero offset (odd, or a multiple of 4 but not of 16) raises `flt_gp_o`.
- R4: With SIMD state enabled, a control word in beat 0 with any of bits 31..16 or bit 6 set raises `flt_gp_o` in the cycle after beat 0 is accepted. No further beat is taken and no register changes.
- R5: Only bits 10..0 of the 16-bit opcode field load. Bits 15..11 of `fop_o` always read zero.
- R6: With `op32_i` set, both pointers load all 32 bits. With `op32_i` clear, only bits 15..0 load and bits 31..16 of each pointer become zero.
- R7: With `simd_os_en_i` clear, the SIMD registers and the control word keep their values and the control word is not checked. The opcode and the pointers still load.
- R8: Loading a control word whose exception flag i (bit i, i = 0..5) is set while its mask (bit 7+i) is clear does not assert `err_o`. A later one-cycle `exc_event_i[i]` pulse with mask i clear asserts `err_o` for one cycle, one clock later. A pulse on a masked exception does not assert `err_o`. Each pulse sets flag i in the control word.
- R9: Beat 0 carries the opcode in bits 15..0, the instruction pointer in bits 63..32, the data pointer in bits 95..64 and the control word in bits 127..96. Beats 10 to 17 carry SIMD registers 0 to 7 in that order, with register i in `vreg_o[128*i +: 128]`. All other beats and bits are ignored.
- R10: `beat_ready_o` is high only while beats are being taken. A successful restore accepts exactly 32 beats and pulses `done_o` in the cycle in which the new values first appear. A fault output is one-hot and lasts one cycle, and `done_o` pulses in the following cycle.
- R11: A synchronous active-high reset clears every register and output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a restore; honoured only when idle |
| img_off_i | input | 4 | Low four bits of the image address |
| lock_pfx_i | input | 1 | Instruction carried a lock prefix |
| op32_i | input | 1 | 1 = 32-bit operand mode, 0 = 16-bit |
| align_chk_i | input | 1 | Alignment-check exception enabled |
| priv_i | input | 2 | Current privilege level |
| simd_os_en_i | input | 1 | Operating system has enabled SIMD state |
| beat_valid_i | input | 1 | Image beat is valid |
| beat_ready_o | output | 1 | Block accepts an image beat |
| beat_data_i | input | 128 | Image beat |
| exc_event_i | input | 6 | New SIMD exception occurrences, one bit per exception |
| fop_o | output | 16 | Restored opcode |
| ip_o | output | 32 | Restored instruction pointer |
| dp_o | output | 32 | Restored data pointer |
| ctl_o | output | 32 | SIMD control/status word |
| vreg_o | output | 1024 | Eight SIMD registers, register i at bits 128*i+127..128*i |
| err_o | output | 1 | SIMD numeric error line |
| flt_ud_o | output | 1 | Invalid-opcode fault pulse |
| flt_gp_o | output | 1 | General-protection fault pulse |
| flt_ac_o | output | 1 | Alignment-check fault pulse |
| done_o | output | 1 | Restore finished |

## Verification
The assertions check the following on every cycle:

- the fault outputs are one-hot
- each fault is followed by `done_o`
- an alignment-check fault only occurs at privilege 3 with checking enabled
- no register moves outside a commit
- SIMD registers hold across a commit with SIMD disabled
- 16-bit commits clear the pointer upper halves
- the error line only rises after a new exception event

Only the bench's scenarios can show the fault chosen for each offset, and the exact placement of fields and registers within the beats. The same holds for the rejection of reserved control bits and the suppression of error on load, where the bench pairs a loaded flag with masked and unmasked events.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

    localparam int BEAT_W    = 128;
    localparam int PTR_W     = 32;
    localparam int CTL_W     = 32;
    localparam int OPC_W     = 16;
    localparam int OPC_KEEP  = 11;
    localparam int N_EXC     = 6;
    localparam int MASK_LSB  = 7;
    localparam int OFF_W     = 4;
    localparam logic [CTL_W-1:0] CTL_RSVD = 32'hFFFF_0040;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_BEATS,
        ST_FDONE
    } st_e;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_UD,
        FLT_GP,
        FLT_AC
    } flt_e;

    typedef struct packed {
        logic             lock;
        logic             op32;
        logic             achk;
        logic [1:0]       priv;
        logic             simd_en;
        logic [OFF_W-1:0] off;
    } dec_t;

    typedef struct packed {
        logic [OPC_KEEP-1:0] fop;
        logic [PTR_W-1:0]    ip;
        logic [PTR_W-1:0]    dp;
        logic [CTL_W-1:0]    ctl;
    } hdr_t;

    // Field positions inside beat 0
    function automatic hdr_t unpack_hdr(input logic [BEAT_W-1:0] b);
        hdr_t h;
        h.fop = b[OPC_KEEP-1:0];
        h.ip  = b[63:32];
        h.dp  = b[95:64];
        h.ctl = b[127:96];
        return h;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_of(input logic [BEAT_W-1:0] b);
        return b[127:96];
    endfunction

endpackage

// File: rtl/xsr_fault_check.sv
module xsr_fault_check
    import xsr_pkg::*;
(
    input  dec_t             dec_i,
    input  logic [CTL_W-1:0] ctl_i,
    output flt_e             pre_flt_o,
    output logic             ctl_bad_o
);

    logic misal;
    logic ac_case;

    always_comb begin
        misal   = (dec_i.off != '0);
        ac_case = dec_i.achk && (dec_i.priv == 2'd3) && (dec_i.off[1:0] == 2'b10);
        if (dec_i.lock)
            pre_flt_o = FLT_UD;
        else if (misal && ac_case)
            pre_flt_o = FLT_AC;
        else if (misal)
            pre_flt_o = FLT_GP;
        else
            pre_flt_o = FLT_NONE;
    end

    // Reserved control bits only matter when SIMD state is enabled
    assign ctl_bad_o = dec_i.simd_en && ((ctl_i & CTL_RSVD) != '0);

endmodule

// File: rtl/xsr_beat_stage.sv
module xsr_beat_stage
    import xsr_pkg::*;
#(
    parameter int N_BEATS   = 32,
    parameter int N_VREG    = 8,
    parameter int VREG_BASE = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart_i,
    input  logic                     accept_i,
    input  logic [BEAT_W-1:0]        beat_i,
    output logic [$clog2(N_BEATS)-1:0] idx_o,
    output logic                     last_o,
    output hdr_t                     hdr_o,
    output logic [N_VREG*BEAT_W-1:0] vreg_o
);

    localparam int IDX_W = $clog2(N_BEATS);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (restart_i)
            idx_q <= '0;
        else if (accept_i)
            idx_q <= idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hdr_o <= '0;
        else if (accept_i && idx_q == '0)
            hdr_o <= unpack_hdr(beat_i);
    end

    for (genvar g = 0; g < N_VREG; g++) begin : g_vslot
        always_ff @(posedge clk) begin
            if (rst)
                vreg_o[g*BEAT_W +: BEAT_W] <= '0;
            else if (accept_i && idx_q == IDX_W'(VREG_BASE + g))
                vreg_o[g*BEAT_W +: BEAT_W] <= beat_i;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == IDX_W'(N_BEATS - 1));

    // R10: the beat counter only moves on an accepted beat or a restart
    p_idx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!accept_i && !restart_i) |=> $stable(idx_q));

endmodule

// File: rtl/xsr_arch_regs.sv
module xsr_arch_regs
    import xsr_pkg::*;
#(
    parameter int N_VREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit_i,
    input  logic                     op32_i,
    input  logic                     simd_en_i,
    input  hdr_t                     hdr_i,
    input  logic [N_VREG*BEAT_W-1:0] vstage_i,
    input  logic [N_EXC-1:0]         exc_event_i,
    output logic [OPC_KEEP-1:0]      fop_o,
    output logic [PTR_W-1:0]         ip_o,
    output logic [PTR_W-1:0]         dp_o,
    output logic [CTL_W-1:0]         ctl_o,
    output logic [N_VREG*BEAT_W-1:0] vreg_o,
    output logic                     err_o
);

    localparam int HALF = PTR_W / 2;

    logic [N_EXC-1:0] unmasked;

    function automatic logic [PTR_W-1:0] size_ptr(input logic [PTR_W-1:0] p, input logic wide);
        return wide ? p : {{HALF{1'b0}}, p[HALF-1:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            fop_o <= '0;
            ip_o  <= '0;
            dp_o  <= '0;
        end else if (commit_i) begin
            fop_o <= hdr_i.fop;
            ip_o  <= size_ptr(hdr_i.ip, op32_i);
            dp_o  <= size_ptr(hdr_i.dp, op32_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            vreg_o <= '0;
        else if (commit_i && simd_en_i)
            vreg_o <= vstage_i;
    end

    // Loaded flags never raise the error line; only new events do
    assign unmasked = ~ctl_o[MASK_LSB +: N_EXC];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o <= '0;
            err_o <= 1'b0;
        end else begin
            err_o <= |(exc_event_i & unmasked);
            if (commit_i && simd_en_i)
                ctl_o <= hdr_i.ctl;
            else
                ctl_o[N_EXC-1:0] <= ctl_o[N_EXC-1:0] | exc_event_i;
        end
    end

    // R1, R4: nothing is written outside a commit
    p_hold_nocommit_r1: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> ($stable(ip_o) && $stable(dp_o) && $stable(fop_o)));

    // R7: SIMD registers hold when the OS has not enabled SIMD state
    p_simd_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !simd_en_i) |=> $stable(vreg_o));

    // R6: 16-bit commits clear the pointer upper halves
    p_ptr16_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !op32_i) |=> (ip_o[PTR_W-1:HALF] == '0 && dp_o[PTR_W-1:HALF] == '0));

    // R8: the error line rises only after a new exception event
    p_no_err_on_load_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_event_i == '0) |=> !err_o);

endmodule

// File: rtl/xsr_restore.sv
module xsr_restore
    import xsr_pkg::*;
#(
    parameter int N_BEATS   = 32,
    parameter int N_VREG    = 8,
    parameter int VREG_BASE = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [3:0]               img_off_i,
    input  logic                     lock_pfx_i,
    input  logic                     op32_i,
    input  logic                     align_chk_i,
    input  logic [1:0]               priv_i,
    input  logic                     simd_os_en_i,
    input  logic                     beat_valid_i,
    output logic                     beat_ready_o,
    input  logic [127:0]             beat_data_i,
    input  logic [5:0]               exc_event_i,
    output logic [15:0]              fop_o,
    output logic [31:0]              ip_o,
    output logic [31:0]              dp_o,
    output logic [31:0]              ctl_o,
    output logic [N_VREG*128-1:0]    vreg_o,
    output logic                     err_o,
    output logic                     flt_ud_o,
    output logic                     flt_gp_o,
    output logic                     flt_ac_o,
    output logic                     done_o
);

    localparam int IDX_W = $clog2(N_BEATS);

    st_e              st_q;
    dec_t             dec_q;
    dec_t             dec_in;
    flt_e             pre_flt;
    logic             ctl_bad;
    logic             accept;
    logic             restart;
    logic             commit;
    logic             last;
    logic [IDX_W-1:0] idx;
    hdr_t             hdr_stg;
    logic [N_VREG*BEAT_W-1:0] vstage;
    logic [OPC_KEEP-1:0] fop_keep;

    assign dec_in = '{lock: lock_pfx_i, op32: op32_i, achk: align_chk_i,
                      priv: priv_i, simd_en: simd_os_en_i, off: img_off_i};

    assign beat_ready_o = (st_q == ST_BEATS);
    assign accept       = beat_ready_o && beat_valid_i;
    assign restart      = (st_q == ST_IDLE) && start_i;
    assign commit       = accept && last;

    xsr_fault_check u_chk (
        .dec_i     (dec_q),
        .ctl_i     (ctl_of(beat_data_i)),
        .pre_flt_o (pre_flt),
        .ctl_bad_o (ctl_bad)
    );

    xsr_beat_stage #(
        .N_BEATS   (N_BEATS),
        .N_VREG    (N_VREG),
        .VREG_BASE (VREG_BASE)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .accept_i  (accept),
        .beat_i    (beat_data_i),
        .idx_o     (idx),
        .last_o    (last),
        .hdr_o     (hdr_stg),
        .vreg_o    (vstage)
    );

    xsr_arch_regs #(
        .N_VREG (N_VREG)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .op32_i      (dec_q.op32),
        .simd_en_i   (dec_q.simd_en),
        .hdr_i       (hdr_stg),
        .vstage_i    (vstage),
        .exc_event_i (exc_event_i),
        .fop_o       (fop_keep),
        .ip_o        (ip_o),
        .dp_o        (dp_o),
        .ctl_o       (ctl_o),
        .vreg_o      (vreg_o),
        .err_o       (err_o)
    );

    assign fop_o = {{(OPC_W-OPC_KEEP){1'b0}}, fop_keep};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            dec_q    <= '0;
            flt_ud_o <= 1'b0;
            flt_gp_o <= 1'b0;
            flt_ac_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            flt_ud_o <= 1'b0;
            flt_gp_o <= 1'b0;
            flt_ac_o <= 1'b0;
            done_o   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dec_q <= dec_in;
                        st_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    case (pre_flt)
                        FLT_UD:  begin flt_ud_o <= 1'b1; st_q <= ST_FDONE; end
                        FLT_GP:  begin flt_gp_o <= 1'b1; st_q <= ST_FDONE; end
                        FLT_AC:  begin flt_ac_o <= 1'b1; st_q <= ST_FDONE; end
                        default: st_q <= ST_BEATS;
                    endcase
                end
                ST_BEATS: begin
                    if (accept) begin
                        if (idx == '0 && ctl_bad) begin
                            flt_gp_o <= 1'b1;
                            st_q     <= ST_FDONE;
                        end else if (last) begin
                            done_o <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                ST_FDONE: begin
                    done_o <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10: fault outputs are one-hot
    p_fault_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flt_ud_o, flt_gp_o, flt_ac_o}));

    // R10: every fault is followed by done
    p_done_after_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (flt_ud_o || flt_gp_o || flt_ac_o) |=> done_o);

    // R1: a lock prefix seen in the check cycle yields invalid opcode
    p_lock_ud_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CHECK && dec_q.lock) |=> flt_ud_o);

    // R3: alignment-check faults only at privilege 3 with checking on
    p_ac_priv_r3: assert property (@(posedge clk) disable iff (rst)
        flt_ac_o |-> (dec_q.achk && dec_q.priv == 2'd3));

endmodule

// File: tb/xsr_restore_bench.sv
module xsr_restore_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, lock_pfx_i = 0, op32_i = 0, align_chk_i = 0, simd_os_en_i = 0;
    logic [3:0] img_off_i = '0;
    logic [1:0] priv_i = '0;
    logic beat_valid_i = 0;
    logic beat_ready_o;
    logic [127:0] beat_data_i = '0;
    logic [5:0] exc_event_i = '0;
    logic [15:0] fop_o;
    logic [31:0] ip_o, dp_o, ctl_o;
    logic [1023:0] vreg_o;
    logic err_o, flt_ud_o, flt_gp_o, flt_ac_o, done_o;

    always #(CLK_P/2) clk = ~clk;

    xsr_restore u_xsr_restore (.*);

    int n_chk = 0, n_fail = 0;
    int got_flt, f_cyc, d_cyc, beats;
    logic [15:0]  e_fop = '0;
    logic [31:0]  e_ip = '0, e_dp = '0, e_ctl = '0;
    logic [127:0] e_v [8];
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_hdr(input logic [15:0] f, input logic [31:0] ip,
                                            input logic [31:0] dp, input logic [31:0] c);
        return {c, dp, ip, 16'hA5A5, f};
    endfunction

    function automatic logic [127:0] junk(input int idx, input logic [31:0] seed);
        return {seed, 32'(idx), ~seed, seed ^ (32'(idx) * 32'h9E37)};
    endfunction

    task automatic run(input logic [3:0] off, input bit lk, input bit m32, input bit ach,
                       input logic [1:0] pv, input bit osen, input logic [127:0] hdr, input logic [31:0] seed);
        @(negedge clk);
        img_off_i = off; lock_pfx_i = lk; op32_i = m32; align_chk_i = ach;
        priv_i = pv; simd_os_en_i = osen; start_i = 1;
        @(negedge clk);
        start_i = 0;
        got_flt = 0; f_cyc = -1; d_cyc = -1; beats = 0;
        for (int c = 0; c < 100; c++) begin
            if (flt_ud_o) begin got_flt = got_flt * 4 + 1; f_cyc = c; end
            if (flt_gp_o) begin got_flt = got_flt * 4 + 2; f_cyc = c; end
            if (flt_ac_o) begin got_flt = got_flt * 4 + 3; f_cyc = c; end
            if (done_o) begin d_cyc = c; break; end
            if (beat_ready_o) begin
                beat_valid_i = 1;
                beat_data_i  = (beats == 0) ? hdr : junk(beats, seed);
            end else begin
                beat_valid_i = 0;
            end
            @(negedge clk);
            if (beat_valid_i) beats++;
        end
        beat_valid_i = 0;
    endtask

    task automatic chk_state(input string tag);
        chk(fop_o == e_fop, {tag, " fop"}, fop_o, e_fop);
        chk(ip_o == e_ip, {tag, " ip"}, ip_o, e_ip);
        chk(dp_o == e_dp, {tag, " dp"}, dp_o, e_dp);
        chk(ctl_o == e_ctl, {tag, " ctl"}, ctl_o, e_ctl);
        for (int i = 0; i < 8; i++)
            chk(vreg_o[i*128 +: 128] == e_v[i], {tag, " vreg"}, vreg_o[i*128 +: 128], e_v[i]);
    endtask

    task automatic t_reset();
        chk(beat_ready_o == 0 && done_o == 0 && err_o == 0, "R11 reset ctl outputs", {beat_ready_o, done_o, err_o}, 0);
        chk({flt_ud_o, flt_gp_o, flt_ac_o} == 0, "R11 reset faults", {flt_ud_o, flt_gp_o, flt_ac_o}, 0);
        for (int i = 0; i < 8; i++) e_v[i] = '0;
        chk_state("R11 reset");
    endtask

    task automatic t_load32();
        run(4'h0, 0, 1, 0, 2'd0, 1, mk_hdr(16'hFFFF, 32'hDEADBEEF, 32'h12345678, 32'h0000_1F80), 32'h1111_2222);
        chk(got_flt == 0, "R10 no fault", got_flt, 0);
        chk(beats == 32, "R10 beat count", beats, 32);
        chk(d_cyc > 0, "R10 done seen", d_cyc, 1);
        e_fop = 16'h07FF; e_ip = 32'hDEADBEEF; e_dp = 32'h12345678; e_ctl = 32'h0000_1F80;
        for (int i = 0; i < 8; i++) e_v[i] = junk(10 + i, 32'h1111_2222);
        chk_state("R5 R6 R9 load32");
        @(negedge clk);
        chk(beat_ready_o == 0 && done_o == 0, "R10 idle after done", {beat_ready_o, done_o}, 0);
    endtask

    task automatic t_load16();
        run(4'h0, 0, 0, 1, 2'd3, 1, mk_hdr(16'h8123, 32'hCAFEF00D, 32'h89AB4321, 32'h0000_7F80), 32'h3333_4444);
        chk(got_flt == 0 && beats == 32, "R6 load16 ok", {got_flt, beats}, 32);
        e_fop = 16'h0123; e_ip = 32'h0000F00D; e_dp = 32'h00004321; e_ctl = 32'h0000_7F80;
        for (int i = 0; i < 8; i++) e_v[i] = junk(10 + i, 32'h3333_4444);
        chk_state("R6 R9 load16");
    endtask

    task automatic t_lock();
        run(4'h2, 1, 1, 1, 2'd3, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h5);
        chk(got_flt == 1, "R1 lock ud", got_flt, 1);
        chk(beats == 0, "R1 no beats", beats, 0);
        chk(d_cyc == f_cyc + 1, "R10 done after fault", d_cyc, f_cyc + 1);
        chk_state("R1 unchanged");
    endtask

    task automatic t_misalign();
        run(4'h8, 0, 1, 0, 2'd3, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h6);
        chk(got_flt == 2 && beats == 0, "R2 off8 gp", got_flt, 2);
        run(4'h2, 0, 1, 1, 2'd0, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h6);
        chk(got_flt == 2, "R2 off2 priv0 gp", got_flt, 2);
        chk_state("R2 unchanged");
    endtask

    task automatic t_ac();
        run(4'h6, 0, 1, 1, 2'd3, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h7);
        chk(got_flt == 3 && beats == 0, "R3 off6 ac", got_flt, 3);
        chk(d_cyc == f_cyc + 1, "R10 ac done", d_cyc, f_cyc + 1);
        run(4'h4, 0, 1, 1, 2'd3, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h7);
        chk(got_flt == 2, "R3 off4 gp", got_flt, 2);
        run(4'h1, 0, 1, 1, 2'd3, 1, mk_hdr(16'h1, 32'h1, 32'h1, 32'h0), 32'h7);
        chk(got_flt == 2, "R3 off1 gp", got_flt, 2);
        chk_state("R3 unchanged");
    endtask

    task automatic t_ctl_rsvd();
        run(4'h0, 0, 1, 0, 2'd0, 1, mk_hdr(16'h55, 32'h77, 32'h88, 32'h0001_1F80), 32'h8);
        chk(got_flt == 2, "R4 upper bit gp", got_flt, 2);
        chk(beats == 1 && f_cyc == 2 && d_cyc == 3, "R4 fault timing", {beats, f_cyc, d_cyc}, {32'd1, 32'd2, 32'd3});
        run(4'h0, 0, 1, 0, 2'd0, 1, mk_hdr(16'h55, 32'h77, 32'h88, 32'h0000_0040), 32'h8);
        chk(got_flt == 2 && beats == 1, "R4 bit6 gp", got_flt, 2);
        chk_state("R4 unchanged");
    endtask

    task automatic t_simd_off();
        run(4'h0, 0, 1, 0, 2'd0, 0, mk_hdr(16'h0456, 32'hA0A0B0B0, 32'hC0C0D0D0, 32'hFFFF_FFFF), 32'h9999_0000);
        chk(got_flt == 0 && beats == 32, "R7 no fault with reserved ctl", {got_flt, beats}, 32);
        e_fop = 16'h0456; e_ip = 32'hA0A0B0B0; e_dp = 32'hC0C0D0D0;
        chk_state("R7 simd kept legacy loaded");
    endtask

    task automatic t_err();
        run(4'h0, 0, 1, 0, 2'd0, 1, mk_hdr(16'h0, 32'h10, 32'h20, 32'h0000_1F01), 32'hABCD);
        chk(got_flt == 0, "R8 load ok", got_flt, 0);
        chk(ctl_o == 32'h0000_1F01, "R8 ctl loaded", ctl_o, 32'h1F01);
        chk(err_o == 0, "R8 no err on load", err_o, 0);
        repeat (3) @(negedge clk);
        chk(err_o == 0, "R8 no err later", err_o, 0);
        exc_event_i = 6'b000010;
        @(negedge clk);
        exc_event_i = '0;
        chk(err_o == 0, "R8 masked event", err_o, 0);
        exc_event_i = 6'b000001;
        @(negedge clk);
        exc_event_i = '0;
        chk(err_o == 1, "R8 new unmasked event", err_o, 1);
        @(negedge clk);
        chk(err_o == 0, "R8 err one cycle", err_o, 0);
        chk(ctl_o == 32'h0000_1F03, "R8 flags sticky", ctl_o, 32'h1F03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_load32();
        t_load16();
        t_lock();
        t_misalign();
        t_ac();
        t_ctl_rsvd();
        t_simd_off();
        t_err();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule